// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block multiplies two 16-bit operands in a single clock cycle. It places the product in a 40-bit accumulator, adds it to the accumulator, or subtracts it from the accumulator. The 8 bits above the 32-bit product range act as guard bits, so repeated accumulation can run well past 32-bit full scale without losing data. An overflow flag shows when the accumulator content no longer fits in 32 bits. A saturate command then clamps that content to the 32-bit full-scale value that has the same sign.

Each operation chooses its own operand format (signed or unsigned for each side) and can add a rounding bias. An execute-enable input models conditional execution: when it is low, the operation is dropped. A second accumulator register can be swapped with the working one in a single cycle, which supports fast context switches. The accumulator is read out as an 8-bit extension field and two 16-bit words.

Top module: `mac40_unit`

## Requirements
- R1: With `op`=1 (multiply) and `exec_en` high, the accumulator holds the exact product, extended to 40 bits, one clock edge later.
- R2: With `op`=2 (multiply-add) and `exec_en` high, the accumulator becomes its old value plus the product, taken modulo 2^40.
- R3: With `op`=3 (multiply-subtract) and `exec_en` high, the accumulator becomes its old value minus the product, taken modulo 2^40.
- R4: The `fmt` input selects how the operands are read. 0 means both are signed. 1 means `x_in` is unsigned and `y_in` is signed. 2 means both are unsigned. 3 behaves as 0.
- R5: When `rnd` is high during op 1, 2 or 3, 0x8000 is added to the 40-bit result.
- R6: `ovf` is high exactly when the active accumulator, read as a signed 40-bit value, lies outside the range -2^31 to 2^31-1.
- R7: With `op`=4 (saturate), `exec_en` high and `ovf` high, the accumulator becomes 0x007FFFFFFF if bit 39 is 0, and 0xFF80000000 if bit 39 is 1. When `ovf` is low, the accumulator is left unchanged.
- R8: When `exec_en` is low, the accumulator is left unchanged whatever `op` is.
- R9: `op` values 0, 5, 6 and 7 leave the accumulator unchanged.
- R10: A cycle with `bank_swap` high exchanges the working accumulator with the shadow accumulator. Any update made in that same cycle is written to the register that was working before the swap.
- R11: After a synchronous reset, both accumulators are zero and `ovf` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_en | input | 1 | Condition result; low drops the operation |
| op | input | 3 | 0 none, 1 multiply, 2 multiply-add, 3 multiply-subtract, 4 saturate |
| fmt | input | 2 | Operand format (see R4) |
| rnd | input | 1 | Add rounding bias 0x8000 |
| x_in | input | 16 | First operand |
| y_in | input | 16 | Second operand |
| bank_swap | input | 1 | Exchange working and shadow accumulators |
| acc_ext | output | 8 | Accumulator bits 39:32 |
| acc_hi | output | 16 | Accumulator bits 31:16 |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| ovf | output | 1 | Working accumulator exceeds 32-bit range |

## Verification
Every operation, the saturate and the swap take effect at the first rising edge after the inputs are applied. The new accumulator fields and the new flag can be read as soon as that edge has passed. The bench drives each input set on a falling edge and compares outputs on the following falling edge, exactly one register stage later, against a 40-bit arithmetic model that keeps both banks. In that same window it confirms that dropped, empty and blocked operations left the value as it was.

// File: rtl/mac40_pkg.sv
// Package: shared operation and format codes for the multiply-accumulate unit.
// Assumes a 3-bit operation field and a 2-bit operand format field.
package mac40_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_MUL  = 3'd1,
        OP_MADD = 3'd2,
        OP_MSUB = 3'd3,
        OP_SAT  = 3'd4
    } mac_op_e;

    typedef enum logic [1:0] {
        FMT_SS = 2'd0,
        FMT_US = 2'd1,
        FMT_UU = 2'd2,
        FMT_XX = 2'd3
    } mac_fmt_e;
endpackage

// File: rtl/mac40_mult.sv
// Module: mac40_mult
// Combinational DW x DW multiplier. Each operand is widened by one bit,
// either signed or unsigned according to the format, so that one signed
// multiply covers every format exactly. The product is then sign-extended
// to the accumulator width.
// Assumes AW >= 2*DW+2.
module mac40_mult #(
    parameter int DW = 16,
    parameter int AW = 40
) (
    input  logic [DW-1:0] x_op,
    input  logic [DW-1:0] y_op,
    input  logic [1:0]    fmt,
    output logic [AW-1:0] prod
);
    import mac40_pkg::*;

    localparam int EW = DW + 1;
    localparam int PW = 2 * EW;

    logic x_signed, y_signed;
    logic signed [EW-1:0] x_ext, y_ext;
    logic signed [PW-1:0] p_full;

    // Decode which operands are read as two's complement.
    always_comb begin
        x_signed = (fmt == FMT_SS) || (fmt == FMT_XX);
        y_signed = (fmt != FMT_UU);
    end

    // Widen the operands and form the exact product.
    always_comb begin
        x_ext  = $signed({x_signed & x_op[DW-1], x_op});
        y_ext  = $signed({y_signed & y_op[DW-1], y_op});
        p_full = x_ext * y_ext;
    end

    generate
        if (AW > PW) begin : g_extend
            // Sign-extend the exact product to the accumulator width.
            always_comb prod = {{(AW-PW){p_full[PW-1]}}, p_full};
        end else begin : g_trim
            // Accumulator no wider than the product: keep the low bits.
            always_comb prod = p_full[AW-1:0];
        end
    endgenerate
endmodule

// File: rtl/mac40_accum.sv
// Module: mac40_accum
// Computes the next accumulator value from the current one, the product,
// the operation code and the round request. It also reports whether the
// current value lies outside the signed range of the PW-bit product.
// Assumes AW > PW and that 2^(RB) lies inside PW.
module mac40_accum #(
    parameter int AW = 40,
    parameter int PW = 32,
    parameter int RB = 15
) (
    input  logic [2:0]    op,
    input  logic          exec_en,
    input  logic          rnd,
    input  logic [AW-1:0] prod,
    input  logic [AW-1:0] acc_cur,
    output logic [AW-1:0] acc_nxt,
    output logic          acc_we,
    output logic          ovf
);
    import mac40_pkg::*;

    localparam int GW = AW - PW + 1;
    localparam logic [AW-1:0] POS_FS = {{GW{1'b0}}, {(PW-1){1'b1}}};
    localparam logic [AW-1:0] NEG_FS = {{GW{1'b1}}, {(PW-1){1'b0}}};
    localparam logic [AW-1:0] RND_BIAS = AW'(1) << RB;

    logic [GW-1:0] guard;
    logic [AW-1:0] base, addend, bias;
    logic          arith;

    // Out-of-range detection: guard bits and product sign bit disagree.
    always_comb begin
        guard = acc_cur[AW-1:PW-1];
        ovf   = !((&guard) || (~|guard));
    end

    // Select the operands of the single adder.
    always_comb begin
        arith  = (op == OP_MUL) || (op == OP_MADD) || (op == OP_MSUB);
        base   = (op == OP_MUL) ? '0 : acc_cur;
        addend = (op == OP_MSUB) ? (~prod + AW'(1)) : prod;
        bias   = rnd ? RND_BIAS : '0;
    end

    // Next value and write enable for each operation.
    always_comb begin
        acc_nxt = acc_cur;
        acc_we  = 1'b0;
        if (exec_en) begin
            if (arith) begin
                acc_nxt = base + addend + bias;
                acc_we  = 1'b1;
            end else if (op == OP_SAT && ovf) begin
                acc_nxt = acc_cur[AW-1] ? NEG_FS : POS_FS;
                acc_we  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mac40_bank.sv
// Module: mac40_bank
// Two accumulator registers with a select bit. A write goes to the
// register that is working at the time, and a swap flips the select bit
// in the same cycle.
// Assumes a synchronous active-low reset that clears both registers.
module mac40_bank #(
    parameter int AW = 40,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] d,
    input  logic          swap,
    output logic [AW-1:0] active,
    output logic [AW-1:0] shadow
);
    logic          sel_q;
    logic [AW-1:0] regs_q [NB];

    // Working-bank select: cleared on reset, flipped on a swap.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel_q <= 1'b0;
        else if (swap) sel_q <= ~sel_q;
    end

    generate
        for (genvar b = 0; b < NB; b++) begin : g_reg
            // One accumulator register, written only while it is selected.
            always_ff @(posedge clk) begin
                if (!rst_n)                        regs_q[b] <= '0;
                else if (we && (sel_q == 1'(b)))   regs_q[b] <= d;
            end
        end
    endgenerate

    // Present the working and shadow registers.
    always_comb begin
        active = regs_q[sel_q];
        shadow = regs_q[~sel_q];
    end

    // R10: after a swap with no write, the old shadow becomes the working value.
    a_r10_swap_brings_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !we) |=> (active == $past(shadow)));
    // R10: a write in a swap cycle lands in the register that then becomes shadow.
    a_r10_swap_write_old: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && we) |=> (shadow == $past(d)));
endmodule

// File: rtl/mac40_unit.sv
// Module: mac40_unit (top)
// Single-cycle multiply / multiply-add / multiply-subtract into a 40-bit
// accumulator with per-operation operand format, rounding bias, an
// overflow flag, a conditional saturate, and a shadow accumulator.
// Assumes inputs are set up before the rising edge; all state is updated
// on that edge.
module mac40_unit #(
    parameter int DW = 16,
    parameter int GB = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  exec_en,
    input  logic [2:0]            op,
    input  logic [1:0]            fmt,
    input  logic                  rnd,
    input  logic [DW-1:0]         x_in,
    input  logic [DW-1:0]         y_in,
    input  logic                  bank_swap,
    output logic [GB-1:0]         acc_ext,
    output logic [DW-1:0]         acc_hi,
    output logic [DW-1:0]         acc_lo,
    output logic                  ovf
);
    import mac40_pkg::*;

    localparam int PW = 2 * DW;
    localparam int AW = PW + GB;
    localparam int RB = DW - 1;

    logic [AW-1:0] prod, acc_cur, acc_shd, acc_nxt;
    logic          acc_we;

    mac40_mult #(.DW(DW), .AW(AW)) u_mult (
        .x_op (x_in),
        .y_op (y_in),
        .fmt  (fmt),
        .prod (prod)
    );

    mac40_accum #(.AW(AW), .PW(PW), .RB(RB)) u_accum (
        .op      (op),
        .exec_en (exec_en),
        .rnd     (rnd),
        .prod    (prod),
        .acc_cur (acc_cur),
        .acc_nxt (acc_nxt),
        .acc_we  (acc_we),
        .ovf     (ovf)
    );

    mac40_bank #(.AW(AW), .NB(2)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (acc_we),
        .d      (acc_nxt),
        .swap   (bank_swap),
        .active (acc_cur),
        .shadow (acc_shd)
    );

    // Split the working accumulator into its three output fields.
    always_comb begin
        acc_ext = acc_cur[AW-1:PW];
        acc_hi  = acc_cur[PW-1:DW];
        acc_lo  = acc_cur[DW-1:0];
    end

    // R8: a dropped operation leaves the accumulator untouched.
    a_r8_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en && !bank_swap) |=> $stable({acc_ext, acc_hi, acc_lo}));
    // R9: an empty operation code leaves the accumulator untouched.
    a_r9_empty_op_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 3'd0 || op > 3'd4) && !bank_swap) |=> $stable({acc_ext, acc_hi, acc_lo}));
    // R7: a saturate taken on overflow brings the value back in range.
    a_r7_sat_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == 3'd4 && ovf && !bank_swap) |=> !ovf);
    // R7: a saturate keeps the sign of the clamped value.
    a_r7_sat_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == 3'd4 && !bank_swap) |=> (acc_ext[GB-1] == $past(acc_ext[GB-1])));
    // R7: a saturate without overflow changes nothing.
    a_r7_sat_no_ovf_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && op == 3'd4 && !ovf && !bank_swap) |=> $stable({acc_ext, acc_hi, acc_lo}));
endmodule

// File: tb/mac40_unit_bench.sv
module mac40_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_en = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  fmt = 2'd0;
    logic        rnd = 1'b0;
    logic [15:0] x_in = '0, y_in = '0;
    logic        bank_swap = 1'b0;
    logic [7:0]  acc_ext;
    logic [15:0] acc_hi, acc_lo;
    logic        ovf;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [39:0] m_bank [2];
    bit          m_sel = 0;

    always #10 clk = ~clk;

    mac40_unit u_mac40_unit (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op(op), .fmt(fmt),
        .rnd(rnd), .x_in(x_in), .y_in(y_in), .bank_swap(bank_swap),
        .acc_ext(acc_ext), .acc_hi(acc_hi), .acc_lo(acc_lo), .ovf(ovf)
    );

    function automatic logic [39:0] f_prod(logic [1:0] f, logic [15:0] a, logic [15:0] b);
        longint av, bv;
        av = (f == 2'd1 || f == 2'd2) ? longint'({48'd0, a}) : longint'($signed(a));
        bv = (f == 2'd2) ? longint'({48'd0, b}) : longint'($signed(b));
        return 40'(av * bv);
    endfunction

    function automatic bit f_ovf(logic [39:0] v);
        longint s;
        s = longint'($signed(v));
        return (s > 64'sd2147483647) || (s < -64'sd2147483648);
    endfunction

    task automatic check(string req, logic [39:0] exp_acc, bit exp_ovf);
        checks++;
        if ({acc_ext, acc_hi, acc_lo} !== exp_acc || ovf !== exp_ovf) begin
            fails++;
            $display("FAIL %s: acc=%h ovf=%b expected acc=%h ovf=%b",
                     req, {acc_ext, acc_hi, acc_lo}, ovf, exp_acc, exp_ovf);
        end
    endtask

    // Apply one input set at a falling edge, update the model, compare one edge later.
    task automatic step(string req, bit en, logic [2:0] o, logic [1:0] f, bit r,
                        logic [15:0] a, logic [15:0] b, bit sw);
        logic [39:0] cur, nxt;
        exec_en = en; op = o; fmt = f; rnd = r; x_in = a; y_in = b; bank_swap = sw;
        cur = m_bank[m_sel];
        nxt = cur;
        if (en) begin
            case (o)
                3'd1: nxt = f_prod(f, a, b) + (r ? 40'h8000 : 40'h0);
                3'd2: nxt = cur + f_prod(f, a, b) + (r ? 40'h8000 : 40'h0);
                3'd3: nxt = cur - f_prod(f, a, b) + (r ? 40'h8000 : 40'h0);
                3'd4: if (f_ovf(cur)) nxt = cur[39] ? 40'hFF80000000 : 40'h007FFFFFFF;
                default: nxt = cur;
            endcase
        end
        m_bank[m_sel] = nxt;
        if (sw) m_sel = ~m_sel;
        @(negedge clk);
        exec_en = 1'b0; op = 3'd0; bank_swap = 1'b0; rnd = 1'b0;
        check(req, m_bank[m_sel], f_ovf(m_bank[m_sel]));
    endtask

    initial begin
        logic [15:0] vals [8];
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234, 16'hFFFE, 16'h5555};
        m_bank[0] = '0; m_bank[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset", 40'h0, 1'b0);

        // Directed corner cases with hand-computed values.
        step("R1 mul ss", 1, 3'd1, 2'd0, 0, 16'h8000, 16'h8000, 0);
        check("R1 mul value", 40'h0040000000, 1'b0);
        step("R2 madd", 1, 3'd2, 2'd0, 0, 16'h8000, 16'h8000, 0);
        step("R6 ovf set", 1, 3'd2, 2'd0, 0, 16'h8000, 16'h8000, 0);
        check("R6 ovf positive", 40'h00C0000000, 1'b1);
        step("R8 disabled", 0, 3'd1, 2'd0, 0, 16'h0001, 16'h0001, 0);
        check("R8 disabled holds", 40'h00C0000000, 1'b1);
        step("R9 empty op", 1, 3'd6, 2'd0, 0, 16'h0001, 16'h0001, 0);
        check("R9 op 6 holds", 40'h00C0000000, 1'b1);
        step("R7 sat pos", 1, 3'd4, 2'd0, 0, 16'h0, 16'h0, 0);
        check("R7 sat positive", 40'h007FFFFFFF, 1'b0);
        step("R7 sat no ovf", 1, 3'd4, 2'd0, 0, 16'h0, 16'h0, 0);
        check("R7 sat without ovf holds", 40'h007FFFFFFF, 1'b0);
        step("R1 mul neg", 1, 3'd1, 2'd0, 0, 16'h8000, 16'h7FFF, 0);
        check("R1 neg product", 40'hFFC0008000, 1'b0);
        step("R3 msub", 1, 3'd3, 2'd0, 0, 16'h8000, 16'h8000, 0);
        step("R3 msub 2", 1, 3'd3, 2'd0, 0, 16'h8000, 16'h8000, 0);
        check("R3 neg overflow", 40'hFF40008000, 1'b1);
        step("R7 sat neg", 1, 3'd4, 2'd0, 0, 16'h0, 16'h0, 0);
        check("R7 sat negative", 40'hFF80000000, 1'b0);
        step("R10 swap", 0, 3'd0, 2'd0, 0, 16'h0, 16'h0, 1);
        check("R10 shadow zero", 40'h0, 1'b0);
        step("R10 swap write", 1, 3'd1, 2'd0, 0, 16'h0005, 16'h0005, 1);
        check("R10 old bank back", 40'hFF80000000, 1'b0);
        step("R10 swap again", 0, 3'd0, 2'd0, 0, 16'h0, 16'h0, 1);
        check("R10 write went to old bank", 40'h0000000019, 1'b0);
        step("R4 uu", 1, 3'd1, 2'd2, 0, 16'hFFFF, 16'hFFFF, 0);
        check("R4 uu max", 40'h00FFFE0001, 1'b1);
        step("R4 us", 1, 3'd1, 2'd1, 0, 16'hFFFF, 16'hFFFF, 0);
        check("R4 us", 40'hFFFFFF0001, 1'b0);
        step("R5 round", 1, 3'd1, 2'd3, 1, 16'h0001, 16'h0001, 0);
        check("R5 round bias", 40'h0000008001, 1'b0);

        // Sweep: operand corners x formats x arithmetic ops x round, running accumulator.
        for (int f = 0; f < 4; f++)
            for (int o = 1; o < 4; o++)
                for (int r = 0; r < 2; r++)
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++)
                            step(o == 1 ? "R1 R4 R5 R6 sweep" : (o == 2 ? "R2 R4 R5 R6 sweep" : "R3 R4 R5 R6 sweep"),
                                 1, 3'(o), 2'(f), r[0], vals[i], vals[j], 0);
        // Saturate after the sweep and exercise big accumulation.
        for (int k = 0; k < 300; k++)
            step("R2 R6 guard", 1, 3'd2, 2'd2, 0, 16'hFFFF, 16'hFFFF, 0);
        step("R7 sat after sweep", 1, 3'd4, 2'd0, 0, 16'h0, 16'h0, 0);

        // Synchronous reset clears both banks.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_bank[0] = '0; m_bank[1] = '0; m_sel = 0;
        check("R11 reset again", 40'h0, 1'b0);
        step("R11 shadow cleared", 0, 3'd0, 2'd0, 0, 16'h0, 16'h0, 1);
        check("R11 shadow zero", 40'h0, 1'b0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: acc=%h ovf=%b expected completion", {acc_ext, acc_hi, acc_lo}, ovf);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule